// File: doc/BRIEF.md
# Timer/Counter with Shared Prescaler

An 8-bit up-counter for a small controller core. It counts either the core's instruction-cycle tick or edges on an external clock pin. The polarity of the counted edge can be chosen. The pin passes through a two-flop synchronizer and an edge detector before it can advance the count, so every pin edge is counted at most once per system clock.

One 8-bit prescaler sits between the tick sources. Software gives it either to the counter, where it divides the selected source, or to a watchdog tick path. When the prescaler serves the watchdog, the counter sees its source at 1:1. When it serves the counter, the watchdog tick passes through undivided.

Software can load the counter through a write port and reads it on a parallel output. A write stops counting for the next two instruction cycles. While the prescaler serves the counter, a write also clears the prescaler. A one-cycle pulse marks each wrap from 0xFF to 0x00.

Top module: `tc_timer`

## Requirements
- R1: While rst_ni is low, count_o is 0x00 and ovf_o is 0. The prescaler count and the synchronizer flops are also cleared.
- R2: ctrl_i has this layout: bit 5 selects the source (0 = internal, 1 = pin), bit 4 selects the edge (0 = rising, 1 = falling), bit 3 assigns the prescaler (0 = counter, 1 = watchdog), and bits 2:0 hold the ratio select. When wr_en_i is high at a clock edge, count_o shows wr_data_i after that edge.
- R3: With bit 5 = 0 and bit 3 = 1, the count rises by one at each clock edge where cyc_en_i is 1, and it holds while cyc_en_i is 0.
- R4: After a write, the count does not advance during the next two clock edges at which cyc_en_i is 1. Edges with cyc_en_i = 0 do not use up this hold.
- R5: With bit 3 = 0, the counter advances once per 2^(sel+1) source ticks, so a select of 0 gives 1:2 and a select of 7 gives 1:256. A write clears the prescaler count, so counting restarts from zero.
- R6: With bit 5 = 1 and bit 4 = 0, each rising edge of ext_clk_i raises the count by one. Take the clock edge that first samples the new pin level as edge 1: the count changes at edge 3. Falling edges are not counted.
- R7: With bit 5 = 1 and bit 4 = 1, falling edges of ext_clk_i are counted and rising edges are not.
- R8: The count wraps from 0xFF to 0x00. ovf_o is high for exactly the one cycle after the wrap, and a write never raises it.
- R9: With bit 3 = 1, wdt_tick_o pulses once for every 2^(sel+1) pulses of wdt_tick_i. It never pulses without wdt_tick_i.
- R10: With bit 3 = 0, wdt_tick_o equals wdt_tick_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_en_i | input | 1 | Instruction-cycle enable, the internal tick |
| ext_clk_i | input | 1 | External clock pin, asynchronous |
| ctrl_i | input | 6 | Control: source, edge, assignment, ratio select |
| wr_en_i | input | 1 | Count register write strobe |
| wr_data_i | input | 8 | Count register write data |
| count_o | output | 8 | Current count |
| ovf_o | output | 1 | Wrap pulse, one cycle |
| wdt_tick_i | input | 1 | Raw watchdog tick |
| wdt_tick_o | output | 1 | Watchdog tick after optional prescaling |

## Verification
A vector table sets up internal-mode runs. Each run writes a start value and then applies a chosen number of instruction cycles. With the prescaler bypassed, runs of one, two and three cycles separate a missing hold from a hold that is too long or too short. Prescaled runs at 1:2, 1:4, 1:8, 1:16 and 1:256 test two things: whether the divider phase is cleared by the write, and whether a prescaler pulse that falls inside the hold is dropped. Directed pin tests cover rising and falling polarity and the exact synchronizer latency. Watchdog-path tests check both prescaler assignments.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int SEL_W = 3;

  typedef struct packed {
    logic             src_ext;    // bit 5
    logic             edge_fall;  // bit 4
    logic             ps_to_wdt;  // bit 3
    logic [SEL_W-1:0] ratio;      // bits 2:0
  } tc_ctrl_t;

  localparam int CTRL_W = $bits(tc_ctrl_t);
endpackage

// File: rtl/tc_pin_sync.sv
module tc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign cur    = sync_q[STAGES-1];
  assign edge_o = fall_sel_i ? (prev_q & ~cur) : (cur & ~prev_q);
endmodule

// File: rtl/tc_prescaler.sv
module tc_prescaler #(
  parameter int PS_W  = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             hit_o
);
  logic [PS_W-1:0] cnt_q;
  logic [PS_W-1:0] mask;

  // bits 0..sel take part in the terminal-count match
  always_comb begin
    for (int b = 0; b < PS_W; b++) mask[b] = (b <= int'(sel_i));
  end

  assign hit_o = tick_i & (&(cnt_q | ~mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tc_write_hold.sv
module tc_write_hold #(
  parameter int HOLD_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic cyc_en_i,
  output logic hold_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  logic [HW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       left_q <= '0;
    else if (wr_i)                     left_q <= HW'(HOLD_CYC);
    else if (cyc_en_i && left_q != '0) left_q <= left_q - 1'b1;
  end

  assign hold_o = (left_q != '0);
endmodule

// File: rtl/tc_timer.sv
module tc_timer
  import tc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PS_W        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_en_i,
  input  logic              ext_clk_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              wr_en_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              ovf_o,
  input  logic              wdt_tick_i,
  output logic              wdt_tick_o
);
  tc_ctrl_t         ctrl;
  logic             ext_edge, src_tick, ps_tick, ps_clr, ps_hit;
  logic             cnt_tick, hold, inc;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  assign ctrl = tc_ctrl_t'(ctrl_i);

  tc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (ext_clk_i),
    .fall_sel_i (ctrl.edge_fall),
    .edge_o     (ext_edge)
  );

  assign src_tick = ctrl.src_ext ? ext_edge : cyc_en_i;
  assign ps_tick  = ctrl.ps_to_wdt ? wdt_tick_i : src_tick;
  assign ps_clr   = wr_en_i & ~ctrl.ps_to_wdt;

  tc_prescaler #(.PS_W(PS_W), .SEL_W(SEL_W)) u_ps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ps_clr),
    .tick_i (ps_tick),
    .sel_i  (ctrl.ratio),
    .hit_o  (ps_hit)
  );

  assign cnt_tick   = ctrl.ps_to_wdt ? src_tick : ps_hit;
  assign wdt_tick_o = ctrl.ps_to_wdt ? ps_hit : wdt_tick_i;

  tc_write_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_en_i),
    .cyc_en_i (cyc_en_i),
    .hold_o   (hold)
  );

  assign inc = cnt_tick & ~hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= ~wr_en_i & inc & (&cnt_q);
      if (wr_en_i)  cnt_q <= wr_data_i;
      else if (inc) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/tc_timer_chk.sv
module tc_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cyc_en_i,
  input logic             src_ext_i,
  input logic             wr_en_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic [CNT_W-1:0] count_o,
  input logic             ovf_o,
  input logic             wdt_tick_i,
  input logic             wdt_tick_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  // R8
  ovf_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> count_o == '0);

  // R8
  ovf_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && ovf_o) |-> $past(count_o) == '1);

  // R2
  wr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(wr_en_i)) |-> count_o == $past(wr_data_i));

  // R4
  hold_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(wr_en_i) && !wr_en_i) |=> count_o == $past(count_o));

  // R3
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_ext_i && !cyc_en_i && !wr_en_i) |=> $stable(count_o));

  // R3
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (count_o == $past(count_o)) || (count_o == CNT_W'($past(count_o) + 1'b1)));

  // R9
  wdt_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_tick_o |-> wdt_tick_i);
endmodule

bind tc_timer tc_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cyc_en_i   (cyc_en_i),
  .src_ext_i  (ctrl_i[5]),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .count_o    (count_o),
  .ovf_o      (ovf_o),
  .wdt_tick_i (wdt_tick_i),
  .wdt_tick_o (wdt_tick_o)
);

// File: tb/tc_timer_bench.sv
module tc_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  typedef struct packed {
    logic [5:0]  ctrl;
    logic [7:0]  data;
    logic [15:0] ncyc;
  } vec_t;

  // ctrl: [5] src, [4] edge, [3] assign, [2:0] ratio
  localparam vec_t VECS [NV] = '{
    '{6'b001000, 8'h10, 16'd1},
    '{6'b001000, 8'h10, 16'd2},
    '{6'b001000, 8'h10, 16'd3},
    '{6'b001000, 8'h20, 16'd10},
    '{6'b001000, 8'hFD, 16'd6},
    '{6'b000000, 8'h00, 16'd2},
    '{6'b000000, 8'h00, 16'd4},
    '{6'b000000, 8'h00, 16'd9},
    '{6'b000001, 8'h40, 16'd12},
    '{6'b000001, 8'h40, 16'd3},
    '{6'b000010, 8'h80, 16'd7},
    '{6'b000010, 8'h80, 16'd8},
    '{6'b000011, 8'h05, 16'd40},
    '{6'b000111, 8'h33, 16'd255},
    '{6'b000111, 8'h33, 16'd256},
    '{6'b001111, 8'hF0, 16'd20},
    '{6'b000001, 8'hFF, 16'd4}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cyc_en = 1'b0;
  logic       ext_clk = 1'b0;
  logic [5:0] ctrl = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] count;
  logic       ovf;
  logic       wdt_in = 1'b0;
  logic       wdt_out;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tc_timer u_tc_timer (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .cyc_en_i   (cyc_en),
    .ext_clk_i  (ext_clk),
    .ctrl_i     (ctrl),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .count_o    (count),
    .ovf_o      (ovf),
    .wdt_tick_i (wdt_in),
    .wdt_tick_o (wdt_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected count after a write and n instruction cycles (R3 R4 R5 R9)
  function automatic logic [7:0] model(input logic [5:0] c, input logic [7:0] d, input int n);
    int p;
    int inc;
    p   = c[3] ? 1 : (1 << (int'(c[2:0]) + 1));
    inc = 0;
    for (int i = 3; i <= n; i++) if (i % p == 0) inc++;
    return 8'(int'(d) + inc);
  endfunction

  task automatic do_write(input logic [5:0] c, input logic [7:0] d);
    ctrl = c; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int hits;
    // R1 reset state
    cycles(3);
    chk("R1 count", count, 0);
    chk("R1 ovf", ovf, 0);
    rst_ni = 1'b1;
    cycles(1);

    // R2 R3 R4 R5 R9 table
    cyc_en = 1'b1;
    for (int v = 0; v < NV; v++) begin
      do_write(VECS[v].ctrl, VECS[v].data);
      cycles(int'(VECS[v].ncyc));
      chk($sformatf("R4/R5 vec %0d", v), count,
          model(VECS[v].ctrl, VECS[v].data, int'(VECS[v].ncyc)));
    end

    // R2 write visible next cycle
    cyc_en = 1'b1;
    do_write(6'b001000, 8'hA5);
    chk("R2 load", count, 8'hA5);

    // R3 idle with cyc_en low
    cycles(5);
    chk("R3 run", count, 8'hA8);
    cyc_en = 1'b0;
    cycles(10);
    chk("R3 idle", count, 8'hA8);

    // R4 hold counts only enabled cycles
    do_write(6'b001000, 8'h60);
    cycles(6);
    cyc_en = 1'b1;
    cycles(2);
    chk("R4 hold", count, 8'h60);
    cycles(1);
    chk("R4 release", count, 8'h61);

    // R8 wrap and pulse
    do_write(6'b001000, 8'hFE);
    cycles(3);
    chk("R8 count ff", count, 8'hFF);
    chk("R8 no ovf", ovf, 0);
    cycles(1);
    chk("R8 wrap", count, 8'h00);
    chk("R8 ovf", ovf, 1);
    cycles(1);
    chk("R8 ovf drop", ovf, 0);
    chk("R8 after", count, 8'h01);
    // R8 write of 0 from ff gives no pulse
    do_write(6'b001000, 8'hFF);
    cyc_en = 1'b0;
    do_write(6'b001000, 8'h00);
    chk("R8 write no ovf", ovf, 0);
    cyc_en = 1'b1;

    // R6 rising, exact latency
    do_write(6'b101000, 8'h00);
    cycles(4);
    ext_clk = 1'b1;
    cycles(2);
    chk("R6 latency", count, 0);
    cycles(1);
    chk("R6 rise", count, 1);
    ext_clk = 1'b0;
    cycles(5);
    chk("R6 no fall", count, 1);

    // R7 falling
    do_write(6'b111000, 8'h00);
    cycles(4);
    ext_clk = 1'b1;
    cycles(5);
    chk("R7 no rise", count, 0);
    ext_clk = 1'b0;
    cycles(5);
    chk("R7 fall", count, 1);

    // R5 pin source through 1:2 prescaler
    do_write(6'b100000, 8'h00);
    cycles(4);
    for (int k = 0; k < 4; k++) begin
      ext_clk = 1'b1; cycles(3);
      ext_clk = 1'b0; cycles(3);
    end
    cycles(3);
    chk("R5 pin div2", count, 2);

    // R10 watchdog tick passes through
    ctrl = 6'b000011;
    cyc_en = 1'b0;
    wdt_in = 1'b1;
    #1;
    chk("R10 pass hi", wdt_out, 1);
    @(negedge clk);
    wdt_in = 1'b0;
    #1;
    chk("R10 pass lo", wdt_out, 0);

    // R9 watchdog prescaled 1:4 from a fresh prescaler
    rst_ni = 1'b0;
    cycles(2);
    ctrl = 6'b001001;
    rst_ni = 1'b1;
    cycles(1);
    hits = 0;
    for (int k = 0; k < 8; k++) begin
      wdt_in = 1'b1;
      #1;
      if (wdt_out) hits++;
      @(negedge clk);
      wdt_in = 1'b0;
      @(negedge clk);
    end
    chk("R9 wdt div4", hits, 2);
    chk("R9 counter idle", count, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule